// File: doc/BRIEF.md
# SCSI Interrupt and Status Logic

This block is the interrupt and status section of a simple parallel SCSI bus controller. It takes the already-synchronized SCSI control lines, the data byte and its parity line. It shows them as a live bus-status byte. It also keeps a second status byte with sticky flags for end of DMA and parity error, the interrupt-active bit, a phase-match indication, and pass-through DMA-request and busy-error bits.

A single interrupt line is raised for two causes. The first is a bus reset: either the SCSI reset line going true, or software setting its own assert-reset command bit. This cause cannot be masked. The second is a parity error found on a checked byte, which interrupts only when both mode enables are set. A bus-reset edge also starts a bounded release-all-bus-signals command toward the bus drivers. Software clears the interrupt and the sticky flags with one reset-interrupt read strobe.

Top module: `scsi_irq_status`

## Requirements
- R1: `bus_stat_o` shows the live lines, from bit 7 down to bit 0: RST, BSY, REQ, MSG, C/D, I/O, SEL, DBP.
- R2: `csr_o` holds, from bit 7 down to bit 0: end of DMA, DMA request, parity error, interrupt active, phase match, busy error, ATN, ACK. Bits 6, 2, 1 and 0 follow their inputs directly. Bit 4 always equals `irq_o`.
- R3: Phase match (`csr_o[3]`) is 1 exactly when {MSG, C/D, I/O} equals `tcr_phase_i[2:0]` (bit 2 against MSG, bit 0 against I/O).
- R4: A rising edge of `bus_rst_i` sets `irq_o` at the next clock edge, whatever the mode enables are.
- R5: A rising edge of `cmd_assert_rst_i` sets `irq_o` in the same way. A level held high does not set it again after a clear.
- R6: A reset edge (R4 or R5) asserts `bus_release_o` from the next clock edge for exactly RELEASE_CYCLES cycles (default 8).
- R7: Data parity is odd. A byte is in error when the eight data bits plus DBP hold an even number of ones.
- R8: A checked byte in error sets the parity flag when `mode_par_chk_i` (mode bit 5) is 1. It sets `irq_o` only when `mode_par_irq_i` (mode bit 4) is also 1.
- R9: Parity is checked only in a cycle with `data_rd_i` or `dma_rx_i` high. An erroneous byte with neither strobe changes no flag and no interrupt.
- R10: A `dma_done_i` pulse sets end of DMA (`csr_o[7]`).
- R11: `irq_clr_i` clears the interrupt, the parity flag and end of DMA at the next edge. When a set condition arrives in the same cycle, the set wins.
- R12: After reset, `irq_o`, `bus_release_o` and the sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | SCSI RST line, true-high |
| bus_bsy_i | input | 1 | SCSI BSY line |
| bus_req_i | input | 1 | SCSI REQ line |
| bus_msg_i | input | 1 | SCSI MSG line |
| bus_cd_i | input | 1 | SCSI C/D line |
| bus_io_i | input | 1 | SCSI I/O line |
| bus_sel_i | input | 1 | SCSI SEL line |
| bus_atn_i | input | 1 | SCSI ATN line |
| bus_ack_i | input | 1 | SCSI ACK line |
| bus_data_i | input | DATA_W | SCSI data byte |
| bus_dbp_i | input | 1 | SCSI data parity line |
| tcr_phase_i | input | 3 | Expected phase {MSG, C/D, I/O} |
| mode_par_chk_i | input | 1 | Parity check enable (mode bit 5) |
| mode_par_irq_i | input | 1 | Parity interrupt enable (mode bit 4) |
| cmd_assert_rst_i | input | 1 | Software assert-reset command bit |
| data_rd_i | input | 1 | Data-register read strobe |
| dma_rx_i | input | 1 | DMA receive byte strobe |
| dma_done_i | input | 1 | DMA transfers finished pulse |
| dma_req_i | input | 1 | DMA request state |
| busy_err_i | input | 1 | Busy error state |
| irq_clr_i | input | 1 | Reset-interrupt read strobe |
| bus_stat_o | output | 8 | Live bus status byte |
| csr_o | output | 8 | Bus and status byte |
| irq_o | output | 1 | Interrupt request |
| bus_release_o | output | 1 | Release all SCSI bus signals |

## Verification
The bench runs all 512 data/parity patterns under every combination of the two mode enables and both check strobes. A wrong parity sense, a missing mode qualification, or a flag tied to the interrupt enable shows up in many of these patterns at once. It checks that an even-parity byte without a strobe changes nothing, and that the reset interrupt fires with the mode enables off. It checks that a held assert-reset level does not fire again after a clear, which a level-sensitive design would get wrong. It measures the release pulse length and makes a set and a clear collide in the same cycle, so that an off-by-one count or a clear-wins priority is caught.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;
  typedef struct packed {
    logic rst;
    logic bsy;
    logic req;
    logic msg;
    logic cd;
    logic io;
    logic sel;
    logic dbp;
  } bus_stat_t;

  typedef struct packed {
    logic eod;
    logic dma_req;
    logic par_err;
    logic irq;
    logic phase_ok;
    logic busy_err;
    logic atn;
    logic ack;
  } csr_t;
endpackage

// File: rtl/scsi_par_check.sv
module scsi_par_check #(
  parameter int DATA_W = 8,
  parameter bit ODD_PARITY = 1'b1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              parity_i,
  input  logic              chk_i,
  input  logic              en_i,
  output logic              err_o
);
  logic ones_odd;
  logic bad;

  assign ones_odd = ^{data_i, parity_i};

  generate
    if (ODD_PARITY) begin : g_odd
      assign bad = ~ones_odd;
    end else begin : g_even
      assign bad = ones_odd;
    end
  endgenerate

  assign err_o = chk_i & en_i & bad;
endmodule

// File: rtl/scsi_rst_watch.sv
module scsi_rst_watch #(
  parameter int RELEASE_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_rst_i,
  input  logic cmd_rst_i,
  output logic edge_o,
  output logic release_o
);
  localparam int CntW = $clog2(RELEASE_CYCLES + 1);
  localparam logic [CntW-1:0] CntLoad = CntW'(RELEASE_CYCLES);

  logic bus_q, cmd_q;
  logic [CntW-1:0] cnt_q;

  // each source edge-detected on its own so a held one cannot mask the other
  assign edge_o = (bus_rst_i & ~bus_q) | (cmd_rst_i & ~cmd_q);
  assign release_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q <= 1'b0;
      cmd_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      bus_q <= bus_rst_i;
      cmd_q <= cmd_rst_i;
      if (edge_o)           cnt_q <= CntLoad;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r6_release_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> release_o);
  a_r6_release_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(release_o) |-> $past(edge_o));
endmodule

// File: rtl/scsi_irq_flags.sv
module scsi_irq_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_edge_i,
  input  logic par_err_i,
  input  logic par_irq_en_i,
  input  logic dma_done_i,
  input  logic clr_i,
  output logic irq_o,
  output logic par_flag_o,
  output logic eod_o
);
  logic irq_set;

  assign irq_set = rst_edge_i | (par_err_i & par_irq_en_i);

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= 1'b0;
      par_flag_o <= 1'b0;
      eod_o      <= 1'b0;
    end else begin
      if (irq_set)     irq_o <= 1'b1;
      else if (clr_i)  irq_o <= 1'b0;
      if (par_err_i)   par_flag_o <= 1'b1;
      else if (clr_i)  par_flag_o <= 1'b0;
      if (dma_done_i)  eod_o <= 1'b1;
      else if (clr_i)  eod_o <= 1'b0;
    end
  end

  a_r4_rst_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_edge_i |=> irq_o);
  a_r8_flag_without_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_i && !par_irq_en_i && !rst_edge_i && !irq_o) |=> (par_flag_o && !irq_o));
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !irq_set && !par_err_i && !dma_done_i) |=> (!irq_o && !par_flag_o && !eod_o));
  a_r10_eod_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_done_i |=> eod_o);
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
  import scsi_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RELEASE_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic              bus_bsy_i,
  input  logic              bus_req_i,
  input  logic              bus_msg_i,
  input  logic              bus_cd_i,
  input  logic              bus_io_i,
  input  logic              bus_sel_i,
  input  logic              bus_atn_i,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_dbp_i,
  input  logic [2:0]        tcr_phase_i,
  input  logic              mode_par_chk_i,
  input  logic              mode_par_irq_i,
  input  logic              cmd_assert_rst_i,
  input  logic              data_rd_i,
  input  logic              dma_rx_i,
  input  logic              dma_done_i,
  input  logic              dma_req_i,
  input  logic              busy_err_i,
  input  logic              irq_clr_i,
  output logic [7:0]        bus_stat_o,
  output logic [7:0]        csr_o,
  output logic              irq_o,
  output logic              bus_release_o
);
  bus_stat_t bus_stat;
  csr_t      csr;
  logic      rst_edge, par_err, irq_q, par_flag, eod;

  scsi_rst_watch #(.RELEASE_CYCLES(RELEASE_CYCLES)) u_rst_watch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_rst_i (bus_rst_i),
    .cmd_rst_i (cmd_assert_rst_i),
    .edge_o    (rst_edge),
    .release_o (bus_release_o)
  );

  scsi_par_check #(.DATA_W(DATA_W), .ODD_PARITY(1'b1)) u_par_check (
    .data_i   (bus_data_i),
    .parity_i (bus_dbp_i),
    .chk_i    (data_rd_i | dma_rx_i),
    .en_i     (mode_par_chk_i),
    .err_o    (par_err)
  );

  scsi_irq_flags u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rst_edge_i   (rst_edge),
    .par_err_i    (par_err),
    .par_irq_en_i (mode_par_irq_i),
    .dma_done_i   (dma_done_i),
    .clr_i        (irq_clr_i),
    .irq_o        (irq_q),
    .par_flag_o   (par_flag),
    .eod_o        (eod)
  );

  always_comb begin
    bus_stat.rst = bus_rst_i;
    bus_stat.bsy = bus_bsy_i;
    bus_stat.req = bus_req_i;
    bus_stat.msg = bus_msg_i;
    bus_stat.cd  = bus_cd_i;
    bus_stat.io  = bus_io_i;
    bus_stat.sel = bus_sel_i;
    bus_stat.dbp = bus_dbp_i;

    csr.eod      = eod;
    csr.dma_req  = dma_req_i;
    csr.par_err  = par_flag;
    csr.irq      = irq_q;
    csr.phase_ok = ({bus_msg_i, bus_cd_i, bus_io_i} == tcr_phase_i);
    csr.busy_err = busy_err_i;
    csr.atn      = bus_atn_i;
    csr.ack      = bus_ack_i;
  end

  assign bus_stat_o = bus_stat;
  assign csr_o      = csr;
  assign irq_o      = irq_q;

  a_r5_cmd_rst_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_assert_rst_i) |=> irq_o);
  a_r8_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(rst_edge || (par_err && mode_par_irq_i)));
  a_r9_no_strobe_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_rd_i && !dma_rx_i && !csr_o[5]) |=> !csr_o[5]);
endmodule

// File: tb/scsi_irq_status_test.sv
`timescale 1ns/1ps
module scsi_irq_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst = 0, bsy = 0, req = 0, msg = 0, cd = 0, io = 0, sel = 0, atn = 0, ack = 0;
  logic [7:0] data = 0;
  logic dbp = 0;
  logic [2:0] tcr = 0;
  logic m_chk = 0, m_irq = 0, cmd_rst = 0, data_rd = 0, dma_rx = 0;
  logic dma_done = 0, dma_req = 0, busy_err = 0, irq_clr = 0;
  logic [7:0] bus_stat, csr;
  logic irq, rel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scsi_irq_status uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst), .bus_bsy_i(bsy), .bus_req_i(req),
    .bus_msg_i(msg), .bus_cd_i(cd), .bus_io_i(io), .bus_sel_i(sel), .bus_atn_i(atn),
    .bus_ack_i(ack), .bus_data_i(data), .bus_dbp_i(dbp), .tcr_phase_i(tcr),
    .mode_par_chk_i(m_chk), .mode_par_irq_i(m_irq), .cmd_assert_rst_i(cmd_rst),
    .data_rd_i(data_rd), .dma_rx_i(dma_rx), .dma_done_i(dma_done), .dma_req_i(dma_req),
    .busy_err_i(busy_err), .irq_clr_i(irq_clr), .bus_stat_o(bus_stat), .csr_o(csr),
    .irq_o(irq), .bus_release_o(rel)
  );

  task automatic chk(input string req_tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk) irq_clr = 1;
    @(negedge clk) irq_clr = 0;
  endtask

  task automatic wait_release();
    while (rel) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 irq", {7'd0, irq}, 8'd0);
    chk("R12 release", {7'd0, rel}, 8'd0);
    chk("R12 sticky", {csr[7], csr[5], csr[4]}, 8'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R12 after release", {csr[7], csr[5], csr[4], irq, rel}, 8'd0);

    // R1 bus status sweep (RST held low; separately below)
    for (int v = 0; v < 128; v++) begin
      @(negedge clk);
      {bsy, req, msg, cd, io, sel, dbp} = v[6:0];
      #1;
      chk("R1 bus_stat", bus_stat, {1'b0, v[6:0]});
    end
    // R3 phase match sweep
    for (int p = 0; p < 8; p++) begin
      for (int t = 0; t < 8; t++) begin
        @(negedge clk);
        {msg, cd, io} = p[2:0];
        tcr = t[2:0];
        #1;
        chk("R3 phase", {7'd0, csr[3]}, {7'd0, p == t});
      end
    end
    // R2 pass-through bits
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      {dma_req, busy_err, atn, ack} = v[3:0];
      #1;
      chk("R2 layout", {1'b0, csr[6], 3'b0, csr[2:0]}, {1'b0, v[3], 3'b0, v[2:0]});
    end
    {dma_req, busy_err, atn, ack} = 0;

    // R4 bus reset line, enables off
    m_chk = 0; m_irq = 0;
    @(negedge clk) bus_rst = 1;
    #1;
    chk("R1 rst bit", {7'd0, bus_stat[7]}, 8'd1);
    chk("R4 no irq before edge", {7'd0, irq}, 8'd0);
    @(negedge clk);
    chk("R4 irq after rst", {7'd0, irq}, 8'd1);
    chk("R2 irq bit", {7'd0, csr[4]}, 8'd1);
    // R6 release length
    begin
      int n = 0;
      while (rel && n < 100) begin n++; @(negedge clk); end
      chk("R6 release cycles", 8'(n), 8'd8);
    end
    bus_rst = 0;
    do_clear();
    chk("R11 irq cleared", {7'd0, irq}, 8'd0);

    // R5 software assert-reset, and held level does not refire
    @(negedge clk) cmd_rst = 1;
    @(negedge clk);
    chk("R5 irq on cmd", {7'd0, irq}, 8'd1);
    chk("R6 release on cmd", {7'd0, rel}, 8'd1);
    do_clear();
    @(negedge clk);
    chk("R5 held no refire", {7'd0, irq}, 8'd0);
    cmd_rst = 0;
    wait_release();

    // R7/R8 exhaustive parity sweep
    for (int src = 0; src < 2; src++) begin
      for (int m = 0; m < 4; m++) begin
        for (int v = 0; v < 512; v++) begin
          logic err;
          err = ~^v[8:0];
          @(negedge clk);
          {m_chk, m_irq} = m[1:0];
          {data, dbp} = v[8:0];
          if (src == 0) data_rd = 1; else dma_rx = 1;
          @(negedge clk);
          data_rd = 0; dma_rx = 0;
          chk("R7 R8 parity flag", {7'd0, csr[5]}, {7'd0, err & m[1]});
          chk("R8 parity irq", {7'd0, irq}, {7'd0, err & m[1] & m[0]});
          if (csr[5] || irq) do_clear();
        end
      end
    end

    // R9 erroneous byte without strobe
    m_chk = 1; m_irq = 1;
    @(negedge clk) {data, dbp} = 9'b0000_0000_0;
    repeat (2) @(negedge clk);
    chk("R9 no strobe flag", {7'd0, csr[5]}, 8'd0);
    chk("R9 no strobe irq", {7'd0, irq}, 8'd0);

    // R10 end of DMA
    @(negedge clk) dma_done = 1;
    @(negedge clk) dma_done = 0;
    chk("R10 eod set", {7'd0, csr[7]}, 8'd1);
    @(negedge clk);
    chk("R10 eod held", {7'd0, csr[7]}, 8'd1);
    // R11 set wins over clear
    @(negedge clk) begin dma_done = 1; irq_clr = 1; end
    @(negedge clk) begin dma_done = 0; irq_clr = 0; end
    chk("R11 set wins", {7'd0, csr[7]}, 8'd1);
    do_clear();
    chk("R11 eod cleared", {7'd0, csr[7]}, 8'd0);
    // R11 parity flag cleared, R8 flag without irq
    m_irq = 0;
    @(negedge clk) data_rd = 1;
    @(negedge clk) data_rd = 0;
    chk("R8 flag no irq", {6'd0, csr[5], irq}, 8'b10);
    do_clear();
    chk("R11 flag cleared", {7'd0, csr[5]}, 8'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule